// File: doc/BRIEF.md
# Split Instruction/Data TLB Lookup with Fault Classification

This block translates 32-bit virtual addresses into physical addresses. It holds two small translation buffers. Execute accesses use the instruction buffer, and read and write accesses use the data buffer. Each buffer is four-way set-associative with sixteen sets, and pages are 8 KB. A lookup request carries the virtual address, the access kind, the current process identifier, two checking enables and a global translation enable.

One clock edge after a request, the block returns the following:
- the physical address;
- the permission flags;
- a hit or fault flag;
- an exception vector number.

On a tag match, a copy of the examined entry goes into two status words. On a miss or fault, the block also loads a select word and a cause word. Refill software reads these to find the slot to write and to see why the access failed.

Entries are loaded through a plain write port that names the buffer, the way, the set and the two entry words. Reset clears the contents. When translation is disabled, the block passes the address through unchanged with every permission granted.

Top module: `tlb_xlate`

## Requirements
- R1: When `mmu_en` is 0, a request returns `rsp_paddr` equal to `req_vaddr`, `rsp_perm` = 3'b111, `rsp_hit` = 1, `rsp_fault` = 0 and `rsp_vec` = 0, and leaves all four status words unchanged.
- R2: The results of a request presented on one rising edge appear on the next rising edge, with `rsp_valid` = 1 for exactly that one cycle. Address splitting and hit output:
  - The page number is `req_vaddr[31:13]` and the set index is `req_vaddr[16:13]`.
  - All four ways at that set are compared.
  - A hit gives `rsp_paddr` = {frame number, `req_vaddr[12:0]`}.
- R3: Access-kind encoding and buffer selection:
  - `req_kind` 2'b10 is execute and uses the instruction buffer (vector base 4).
  - 2'b00 is read, 2'b01 is write, and 2'b11 is treated as read; these use the data buffer (vector base 8).
  - `wr_data_tlb` = 1 writes the data buffer and 0 writes the instruction buffer.
  - A written entry is visible to lookups from the next cycle.
- R4: Entry word layout:
  - High word: page number in [31:13], owner process identifier in [7:0].
  - Low word: frame number in [31:13], global [4], valid [3], kernel [2], write [1], execute [0].
- R5: A lookup whose page number matches no way at its set is a fault with `rsp_vec` equal to the vector base.
- R6: A matching non-global entry whose owner identifier differs from `req_pid` is a fault with vector base + 0. This check takes precedence over every other check. A global entry ignores the identifier.
- R7: A write access with `cfg_wchk` = 1 to a matching entry whose write bit is clear is a fault with vector base + 3. This check takes precedence over the valid check.
- R8: When `cfg_vchk` = 1, a matching entry whose valid bit is clear is a fault with vector base + 1. This is the lowest-priority check.
- R9: Permission flags:
  - On a hit, `rsp_perm[0]` (read) = 1, `rsp_perm[1]` (write) equals the entry write bit, and `rsp_perm[2]` (execute) equals the entry execute bit.
  - On a fault, `rsp_perm` = 0 and `rsp_paddr` = 0.
- R10: Select and cause words:
  - On any miss or fault, `st_sel` is loaded with the set index in [3:0] and 0 in every other bit, with way 0 in bit 4.
  - On any miss or fault, `st_cause` is loaded with the page number in [31:13], an access code in [9:8] (read 01, write 10, execute 11), `req_pid` in [7:0] and zeros elsewhere.
  - Both words are unchanged on a hit.
- R11: On any tag match, hit or fault, `st_tlb_hi` and `st_tlb_lo` take the matched entry's high and low words. They are unchanged on a miss.
- R12: Reset clears every entry, every status word and every response output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 execute) |
| req_pid | input | 8 | Current process identifier |
| cfg_wchk | input | 1 | Enable write-protection checking |
| cfg_vchk | input | 1 | Enable valid-bit checking |
| mmu_en | input | 1 | Global translation enable |
| wr_en | input | 1 | Entry write strobe |
| wr_data_tlb | input | 1 | Target buffer: 1 data, 0 instruction |
| wr_way | input | 2 | Target way |
| wr_idx | input | 4 | Target set |
| wr_hi | input | 32 | Entry high word |
| wr_lo | input | 32 | Entry low word |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Miss or protection fault |
| rsp_vec | output | 4 | Exception vector on fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted permissions {exec, write, read} |
| st_sel | output | 32 | Refill slot select word |
| st_cause | output | 32 | Fault cause word |
| st_tlb_hi | output | 32 | High word of last matched entry |
| st_tlb_lo | output | 32 | Low word of last matched entry |

## Verification
The assertions take for granted several things about the inputs:
- `req_kind` and the checking enables are held stable only for the request cycle they belong to.
- Software never places the same page number in two ways of one set. Otherwise the lowest way wins silently.
- No entry write targets the set being looked up in the same cycle.

The directed stimulus keeps within these limits. It gives every entry a distinct page number per set, performs each fill before any lookup that depends on it, and drives every request for exactly one cycle with its configuration bits set in that cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_BITS = 13;
    localparam int VPN_W     = 32 - PAGE_BITS;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_MISS  = 3'd1,
        FC_PID   = 3'd2,
        FC_WPROT = 3'd3,
        FC_INVAL = 3'd4
    } fault_class_e;

    localparam logic [1:0] KIND_READ  = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b01;
    localparam logic [1:0] KIND_EXEC  = 2'b10;

    function automatic logic [VPN_W-1:0] ent_page(input logic [31:0] hi);
        return hi[31:PAGE_BITS];
    endfunction

    function automatic logic [7:0] ent_owner(input logic [31:0] hi);
        return hi[7:0];
    endfunction

    function automatic logic [VPN_W-1:0] ent_frame(input logic [31:0] lo);
        return lo[31:PAGE_BITS];
    endfunction

    function automatic logic ent_global(input logic [31:0] lo);
        return lo[4];
    endfunction

    function automatic logic ent_valid(input logic [31:0] lo);
        return lo[3];
    endfunction

    function automatic logic ent_wr(input logic [31:0] lo);
        return lo[1];
    endfunction

    function automatic logic ent_ex(input logic [31:0] lo);
        return lo[0];
    endfunction

    function automatic logic [3:0] vec_base(input logic is_instr);
        return is_instr ? 4'd4 : 4'd8;
    endfunction

    function automatic logic [3:0] vec_offset(input fault_class_e fc);
        case (fc)
            FC_WPROT: return 4'd3;
            FC_INVAL: return 4'd1;
            default:  return 4'd0;
        endcase
    endfunction

    function automatic logic [1:0] cause_code(input logic [1:0] kind);
        case (kind)
            KIND_WRITE: return 2'b10;
            KIND_EXEC:  return 2'b11;
            default:    return 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [IDX_W-1:0]            wr_idx,
    input  tlb_entry_t                  wr_entry,
    input  logic [IDX_W-1:0]            rd_idx,
    output tlb_entry_t [WAYS-1:0]       rd_entries
);

    tlb_entry_t store [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    store[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            store[wr_idx][wr_way] <= wr_entry;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_entries[w] = store[rd_idx][w];
        end
    end

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> store[$past(wr_idx)][$past(wr_way)] == $past(wr_entry)); // R3

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  tlb_entry_t [WAYS-1:0]   entries,
    input  logic [VPN_W-1:0]        page,
    input  logic [7:0]              pid,
    input  logic                    is_write,
    input  logic                    wchk,
    input  logic                    vchk,
    output logic                    tag_match,
    output tlb_entry_t              match_entry,
    output fault_class_e            fclass
);

    always_comb begin
        tag_match   = 1'b0;
        match_entry = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ent_page(entries[w].hi) == page) begin
                tag_match   = 1'b1;
                match_entry = entries[w];
            end
        end
    end

    always_comb begin
        if (!tag_match)
            fclass = FC_MISS;
        else if (!ent_global(match_entry.lo) && ent_owner(match_entry.hi) != pid)
            fclass = FC_PID;
        else if (is_write && wchk && !ent_wr(match_entry.lo))
            fclass = FC_WPROT;
        else if (vchk && !ent_valid(match_entry.lo))
            fclass = FC_INVAL;
        else
            fclass = FC_NONE;
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [31:0]        req_vaddr,
    input  logic [1:0]         req_kind,
    input  logic [7:0]         req_pid,
    input  logic               cfg_wchk,
    input  logic               cfg_vchk,
    input  logic               mmu_en,
    input  logic               wr_en,
    input  logic               wr_data_tlb,
    input  logic [WAY_W-1:0]   wr_way,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [31:0]        wr_hi,
    input  logic [31:0]        wr_lo,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [3:0]         rsp_vec,
    output logic [31:0]        rsp_paddr,
    output logic [2:0]         rsp_perm,
    output logic [31:0]        st_sel,
    output logic [31:0]        st_cause,
    output logic [31:0]        st_tlb_hi,
    output logic [31:0]        st_tlb_lo
);

    localparam int NBANK = 2;

    logic [VPN_W-1:0]     req_page;
    logic [IDX_W-1:0]     req_idx;
    logic                 is_instr;
    logic                 is_write;
    tlb_entry_t [WAYS-1:0] bank_rd [NBANK];
    tlb_entry_t [WAYS-1:0] cand;
    logic                 tag_match;
    tlb_entry_t           match_entry;
    fault_class_e         fclass;

    assign req_page = req_vaddr[31:PAGE_BITS];
    assign req_idx  = req_vaddr[PAGE_BITS +: IDX_W];
    assign is_instr = (req_kind == KIND_EXEC);
    assign is_write = (req_kind == KIND_WRITE);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        tlb_bank #(.WAYS(WAYS), .SETS(SETS)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_en && (wr_data_tlb == (g == 1))),
            .wr_way     (wr_way),
            .wr_idx     (wr_idx),
            .wr_entry   ('{hi: wr_hi, lo: wr_lo}),
            .rd_idx     (req_idx),
            .rd_entries (bank_rd[g])
        );
    end

    assign cand = is_instr ? bank_rd[0] : bank_rd[1];

    tlb_probe #(.WAYS(WAYS)) u_probe (
        .entries     (cand),
        .page        (req_page),
        .pid         (req_pid),
        .is_write    (is_write),
        .wchk        (cfg_wchk),
        .vchk        (cfg_vchk),
        .tag_match   (tag_match),
        .match_entry (match_entry),
        .fclass      (fclass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_vec   <= '0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
            st_sel    <= '0;
            st_cause  <= '0;
            st_tlb_hi <= '0;
            st_tlb_lo <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (!mmu_en) begin
                    rsp_hit   <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_vec   <= '0;
                    rsp_paddr <= req_vaddr;
                    rsp_perm  <= 3'b111;
                end else begin
                    rsp_hit   <= (fclass == FC_NONE);
                    rsp_fault <= (fclass != FC_NONE);
                    if (fclass == FC_NONE) begin
                        rsp_vec   <= '0;
                        rsp_paddr <= {ent_frame(match_entry.lo), req_vaddr[PAGE_BITS-1:0]};
                        rsp_perm  <= {ent_ex(match_entry.lo), ent_wr(match_entry.lo), 1'b1};
                    end else begin
                        rsp_vec   <= vec_base(is_instr) + vec_offset(fclass);
                        rsp_paddr <= '0;
                        rsp_perm  <= '0;
                        st_sel    <= 32'(req_idx);
                        st_cause  <= {req_page, 3'b000, cause_code(req_kind), req_pid};
                    end
                    if (tag_match) begin
                        st_tlb_hi <= match_entry.hi;
                        st_tlb_lo <= match_entry.lo;
                    end
                end
            end
        end
    end

    AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
        req_valid && !mmu_en |=> rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111 && rsp_hit); // R1
    AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])); // R2
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |->
            (rsp_vec == vec_base($past(req_kind) == KIND_EXEC)
          || rsp_vec == vec_base($past(req_kind) == KIND_EXEC) + 4'd1
          || rsp_vec == vec_base($past(req_kind) == KIND_EXEC) + 4'd3)); // R3
    AST_WPROT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault && (rsp_vec == 4'd7 || rsp_vec == 4'd11)
            |-> $past(req_kind) == KIND_WRITE && $past(cfg_wchk)); // R7
    AST_HIT_GRANTS_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_perm[0]); // R9
    AST_FAULT_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> rsp_perm == 3'b000 && !rsp_hit); // R9
    AST_SEL_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault |-> st_sel == 32'($past(req_vaddr[PAGE_BITS +: IDX_W]))); // R10
    AST_STATUS_HELD_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> $stable(st_sel) && $stable(st_cause)); // R10

endmodule

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [7:0]  req_pid;
    logic        cfg_wchk;
    logic        cfg_vchk;
    logic        mmu_en;
    logic        wr_en;
    logic        wr_data_tlb;
    logic [1:0]  wr_way;
    logic [3:0]  wr_idx;
    logic [31:0] wr_hi;
    logic [31:0] wr_lo;
    logic        rsp_valid;
    logic        rsp_hit;
    logic        rsp_fault;
    logic [3:0]  rsp_vec;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [31:0] st_sel;
    logic [31:0] st_cause;
    logic [31:0] st_tlb_hi;
    logic [31:0] st_tlb_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tlb_xlate u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_pid(req_pid), .cfg_wchk(cfg_wchk),
        .cfg_vchk(cfg_vchk), .mmu_en(mmu_en), .wr_en(wr_en),
        .wr_data_tlb(wr_data_tlb), .wr_way(wr_way), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_vec(rsp_vec), .rsp_paddr(rsp_paddr),
        .rsp_perm(rsp_perm), .st_sel(st_sel), .st_cause(st_cause),
        .st_tlb_hi(st_tlb_hi), .st_tlb_lo(st_tlb_lo)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic fill(input logic dbank, input logic [1:0] way, input logic [3:0] idx,
                        input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        wr_en = 1'b1; wr_data_tlb = dbank; wr_way = way; wr_idx = idx; wr_hi = hi; wr_lo = lo;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic [7:0] pid,
                          input logic wchk, input logic vchk, input logic en);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_pid = pid;
        cfg_wchk = wchk; cfg_vchk = vchk; mmu_en = en;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R12 rsp_valid", 32'(rsp_valid), 0);
        chk("R12 st_sel", st_sel, 0);
        chk("R12 st_cause", st_cause, 0);
        chk("R12 st_tlb_hi", st_tlb_hi, 0);
        chk("R12 st_tlb_lo", st_tlb_lo, 0);
        lookup(32'h4000_6000, 2'b00, 8'h05, 1'b1, 1'b1, 1'b1);
        chk("R5 miss fault", 32'(rsp_fault), 1);
        chk("R5 miss vec data", 32'(rsp_vec), 8);
        chk("R10 sel on miss", st_sel, 32'h3);
        chk("R10 cause on miss", st_cause, 32'h4000_6105);
        chk("R11 hi kept on miss", st_tlb_hi, 0);
        chk("R9 miss perm", 32'(rsp_perm), 0);
    endtask

    task automatic t_bypass;
        lookup(32'h1234_5678, 2'b01, 8'h01, 1'b1, 1'b1, 1'b0);
        chk("R1 paddr", rsp_paddr, 32'h1234_5678);
        chk("R1 perm", 32'(rsp_perm), 32'h7);
        chk("R1 hit", 32'(rsp_hit), 1);
        chk("R1 vec", 32'(rsp_vec), 0);
        chk("R1 cause kept", st_cause, 32'h4000_6105);
    endtask

    task automatic t_data_hit;
        fill(1'b1, 2'd2, 4'd3, 32'h4000_6005, 32'h1579_800A);
        lookup(32'h4000_7ABC, 2'b00, 8'h05, 1'b1, 1'b1, 1'b1);
        chk("R2 valid", 32'(rsp_valid), 1);
        chk("R2 hit", 32'(rsp_hit), 1);
        chk("R2 paddr", rsp_paddr, 32'h1579_9ABC);
        chk("R9 perm rw", 32'(rsp_perm), 32'h3);
        chk("R11 tlb hi", st_tlb_hi, 32'h4000_6005);
        chk("R11 tlb lo", st_tlb_lo, 32'h1579_800A);
        chk("R10 cause kept on hit", st_cause, 32'h4000_6105);
        @(negedge clk);
        chk("R2 valid one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic t_split;
        lookup(32'h4000_6000, 2'b10, 8'h05, 1'b1, 1'b1, 1'b1);
        chk("R3 exec uses instr tlb miss", 32'(rsp_fault), 1);
        chk("R3 instr vec base", 32'(rsp_vec), 4);
        chk("R10 exec cause code", st_cause, 32'h4000_6305);
        fill(1'b0, 2'd0, 4'd3, 32'h4000_6005, 32'h2222_0019);
        lookup(32'h4000_6010, 2'b10, 8'h09, 1'b1, 1'b1, 1'b1);
        chk("R6 global ignores pid", 32'(rsp_hit), 1);
        chk("R4 frame field", rsp_paddr, 32'h2222_0010);
        chk("R9 perm rx", 32'(rsp_perm), 32'h5);
        lookup(32'h4000_6010, 2'b11, 8'h05, 1'b0, 1'b1, 1'b1);
        chk("R3 kind 11 reads data tlb", rsp_paddr, 32'h1579_8010);
    endtask

    task automatic t_pid;
        lookup(32'h4000_6000, 2'b00, 8'h06, 1'b1, 1'b1, 1'b1);
        chk("R6 pid fault", 32'(rsp_fault), 1);
        chk("R6 pid vec", 32'(rsp_vec), 8);
        chk("R10 cause pid", st_cause, 32'h4000_6106);
        chk("R11 hi on fault", st_tlb_hi, 32'h4000_6005);
    endtask

    task automatic t_wprot;
        fill(1'b1, 2'd1, 4'd7, 32'h0000_E022, 32'h0020_0008);
        lookup(32'h0000_E100, 2'b01, 8'h22, 1'b1, 1'b1, 1'b1);
        chk("R7 wp vec", 32'(rsp_vec), 11);
        chk("R10 sel idx7", st_sel, 32'h7);
        chk("R10 cause write", st_cause, 32'h0000_E222);
        lookup(32'h0000_E100, 2'b01, 8'h22, 1'b0, 1'b1, 1'b1);
        chk("R7 wchk off hit", rsp_paddr, 32'h0020_0100);
        chk("R9 perm r only", 32'(rsp_perm), 32'h1);
        lookup(32'h0000_E100, 2'b01, 8'h23, 1'b1, 1'b1, 1'b1);
        chk("R6 pid over R7", 32'(rsp_vec), 8);
    endtask

    task automatic t_invalid;
        fill(1'b1, 2'd3, 4'd7, 32'h0002_E022, 32'h0040_0002);
        lookup(32'h0002_E004, 2'b00, 8'h22, 1'b1, 1'b1, 1'b1);
        chk("R8 invalid vec", 32'(rsp_vec), 9);
        lookup(32'h0002_E004, 2'b00, 8'h22, 1'b1, 1'b0, 1'b1);
        chk("R8 vchk off hit", rsp_paddr, 32'h0040_0004);
        fill(1'b1, 2'd0, 4'd9, 32'h0001_2022, 32'h0060_0000);
        lookup(32'h0001_2000, 2'b01, 8'h22, 1'b1, 1'b1, 1'b1);
        chk("R7 wp over R8", 32'(rsp_vec), 11);
        chk("R10 sel idx9", st_sel, 32'h9);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_pid = '0;
        cfg_wchk = 1'b0; cfg_vchk = 1'b0; mmu_en = 1'b0;
        wr_en = 1'b0; wr_data_tlb = 1'b0; wr_way = '0; wr_idx = '0; wr_hi = '0; wr_lo = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_bypass();
        t_data_hit();
        t_split();
        t_pid();
        t_wprot();
        t_invalid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule